// File: doc/BRIEF.md
# Viterbi Path Metric Update Engine

This block performs the add-compare-select part of a hard-decision, rate-1/2 Viterbi decoder with a 32-state trellis (constraint length 6). Each accepted 2-bit received symbol triggers one full trellis step. The engine visits the 16 butterflies one per clock. For each butterfly it reads two old path metrics and rebuilds the expected encoder output on all four branches from the two generator polynomials. The branch metric counts how many symbol bits agree with the expected output. Each destination keeps the larger of its two candidate sums.

The result of a step is published all at once. The published outputs are the full 32-entry metric array and a 32-bit survivor decision vector, and a one-cycle done pulse marks their arrival. A traceback unit downstream would collect the decision vectors. The path metrics are held as an ordered score, so any common rescaling is harmless. The engine therefore halves the whole array whenever a freshly computed metric would reach the top bit.

Top module: `vit_pm_engine`

## Requirements
- R1: `sym_ready` is high only while the engine is idle. A symbol is taken on a clock edge where `sym_valid` and `sym_ready` are both high. `sym_ready` stays low from that edge until `done` rises.
- R2: `done` is high for exactly one cycle. That cycle follows the 17th clock edge after the accepting edge, which covers 16 butterfly cycles and one publish cycle.
- R3: After reset, `pm_out` holds the bias 64 for state 0 and 0 for every other state. `dec_out` is all zeros, `sym_ready` is 1 and `done` is 0. State k occupies `pm_out[8k+7:8k]`.
- R4: The expected branch output for source state s and input bit u is computed from the 6-bit word {u, s[4:0]}. Output bit 1 is the XOR of that word ANDed with 6'b101101, and output bit 0 is the XOR of that word ANDed with 6'b110111. The branch metric is the number of positions in which this output equals `sym_data` (0, 1 or 2). For example, source 5'b00100 with u=1 gives 2'b00, so symbol 2'b11 scores 0 on that branch.
- R5: For each 4-bit value p, destination states {p,0} (input 0) and {p,1} (input 1) are both fed by sources {0,p} and {1,p}. Each destination receives the larger of (source metric + branch metric) over its two sources.
- R6: Bit k of `dec_out` is 0 if destination k took its metric from source {0,p} and 1 if it came from {1,p}. Equal candidates resolve to source {0,p}, with decision 0.
- R7: If any newly computed metric has bit 7 set, every new metric is shifted right by one before it is published. All published metrics are therefore below 128.
- R8: All 32 new metrics of a step are computed from the metrics published by the previous step, never from values written earlier in the same step.
- R9: `pm_out` and `dec_out` change only on the edge that makes `done` rise.
- R10: `sym_valid` and `sym_data` are ignored while the engine is busy. A step's result depends only on the symbol present at its accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | Received symbol is present |
| sym_data | input | 2 | Received hard-decision symbol |
| sym_ready | output | 1 | Engine can take a symbol |
| done | output | 1 | One-cycle pulse: new step published |
| pm_out | output | 256 | Published path metrics, 8 bits per state |
| dec_out | output | 32 | Published survivor decisions, one per state |

## Verification
The hardest case to reach is the rescaling step, because metrics grow by at most two per symbol from a bias of 64. Rescaling only happens after dozens of consecutive steps, and only if the received stream keeps agreeing with some path. The stimulus drives a long run of random symbols followed by a run of constant symbols. A scoreboard model steps the trellis independently and counts the steps in which it had to halve. The bench insists that at least one such step occurred. A second awkward case is a symbol that changes while the engine is busy. The driver keeps `sym_valid` asserted with altered data throughout one step and expects the result of the original symbol only.

// File: rtl/vit_pkg.sv
// Package: shared control-state encoding and tap-parity helper for the
// Viterbi path metric engine. Assumes taps fit in 16 bits.
package vit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_COMMIT = 2'd2
    } vit_state_e;

    // XOR-reduce a tapped shift-register word
    function automatic logic tap_parity(input logic [15:0] taps);
        return ^taps;
    endfunction

endpackage

// File: rtl/vit_bmu.sv
// Branch metric unit: rebuilds the expected 2-bit encoder output for one
// branch (input bit plus source state) and counts agreements with the
// received symbol. Assumes symbol bit 1 pairs with G0 and bit 0 with G1.
module vit_bmu #(
    parameter int            SW = 5,
    parameter logic [SW:0]   G0 = 6'b101101,
    parameter logic [SW:0]   G1 = 6'b110111
) (
    input  logic [SW-1:0] src_state,
    input  logic          in_bit,
    input  logic [1:0]    sym,
    output logic [1:0]    bm
);
    import vit_pkg::*;

    localparam int CL = SW + 1;

    logic [CL-1:0] reg_word;
    logic [1:0]    expected;
    logic [1:0]    agree;

    assign reg_word = {in_bit, src_state};

    // One parity tree per generator polynomial
    for (genvar g = 0; g < 2; g++) begin : g_poly
        localparam logic [CL-1:0] POLY = (g == 0) ? G0 : G1;
        always_comb begin
            // expected output bit for this polynomial
            expected[1-g] = tap_parity(16'(reg_word & POLY));
        end
    end

    // Agreement count between expected output and received symbol
    always_comb begin
        agree = ~(expected ^ sym);
        bm    = {1'b0, agree[1]} + {1'b0, agree[0]};
    end

endmodule

// File: rtl/vit_acs.sv
// Butterfly add-compare-select: given the metrics of sources {0,p} and
// {1,p}, produces metrics and decisions for destinations {p,0} and {p,1}.
// Ties favour source {0,p}. Assumes inputs below 2^(MW-1) so sums fit.
module vit_acs #(
    parameter int            SW = 5,
    parameter int            MW = 8,
    parameter logic [SW:0]   G0 = 6'b101101,
    parameter logic [SW:0]   G1 = 6'b110111
) (
    input  logic [SW-2:0] pair_id,
    input  logic [MW-1:0] pm_lo,
    input  logic [MW-1:0] pm_hi,
    input  logic [1:0]    sym,
    output logic [MW-1:0] new_pm [2],
    output logic          new_dec [2]
);
    logic [SW-1:0] src_lo;
    logic [SW-1:0] src_hi;

    assign src_lo = {1'b0, pair_id};
    assign src_hi = {1'b1, pair_id};

    // One destination per branch input bit
    for (genvar b = 0; b < 2; b++) begin : g_dst
        logic [1:0]    bm_lo;
        logic [1:0]    bm_hi;
        logic [MW-1:0] cand_lo;
        logic [MW-1:0] cand_hi;

        vit_bmu #(.SW(SW), .G0(G0), .G1(G1)) u_bmu_lo (
            .src_state (src_lo),
            .in_bit    (1'(b)),
            .sym       (sym),
            .bm        (bm_lo)
        );

        vit_bmu #(.SW(SW), .G0(G0), .G1(G1)) u_bmu_hi (
            .src_state (src_hi),
            .in_bit    (1'(b)),
            .sym       (sym),
            .bm        (bm_hi)
        );

        // Add both candidates, keep the larger, ties to the low source
        always_comb begin
            cand_lo    = pm_lo + {{(MW-2){1'b0}}, bm_lo};
            cand_hi    = pm_hi + {{(MW-2){1'b0}}, bm_hi};
            new_dec[b] = (cand_hi > cand_lo);
            new_pm[b]  = new_dec[b] ? cand_hi : cand_lo;
        end
    end

endmodule

// File: rtl/vit_ctrl.sv
// Step sequencer: accepts a symbol when idle, walks NB butterflies one per
// clock, then spends one cycle publishing and pulses done.
module vit_ctrl #(
    parameter int NB = 16,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sym_valid,
    output logic          sym_ready,
    output logic          accept,
    output logic          bfly_en,
    output logic [IW-1:0] bfly_idx,
    output logic          commit,
    output logic          done
);
    import vit_pkg::*;

    vit_state_e state_q;
    logic [IW-1:0] idx_q;
    logic          done_q;

    assign sym_ready = (state_q == ST_IDLE);
    assign accept    = sym_ready && sym_valid;
    assign bfly_en   = (state_q == ST_RUN);
    assign commit    = (state_q == ST_COMMIT);
    assign bfly_idx  = idx_q;
    assign done      = done_q;

    // State, butterfly counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (sym_valid) begin
                        state_q <= ST_RUN;
                        idx_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (idx_q == IW'(NB - 1)) begin
                        state_q <= ST_COMMIT;
                    end
                    idx_q <= idx_q + 1'b1;
                end
                ST_COMMIT: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vit_metric_bank.sv
// Double-buffered metric store. Butterflies read the published bank and
// write a staging bank; commit copies staging to published, halving all
// entries if any staging entry has its top bit set. Decisions are staged
// and published alongside.
module vit_metric_bank #(
    parameter int SW        = 5,
    parameter int MW        = 8,
    parameter int INIT_BIAS = 64,
    localparam int NS = 1 << SW,
    localparam int IW = SW - 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [IW-1:0]  idx,
    output logic [MW-1:0]  rd_lo,
    output logic [MW-1:0]  rd_hi,
    input  logic           wr_en,
    input  logic [MW-1:0]  wr_pm [2],
    input  logic           wr_dec [2],
    input  logic           commit,
    output logic [NS*MW-1:0] pm_flat,
    output logic [NS-1:0]  dec_flat
);
    logic [MW-1:0] pub_q [NS];
    logic [MW-1:0] stg_q [NS];
    logic [NS-1:0] dec_stg_q;
    logic [NS-1:0] dec_pub_q;
    logic          any_top;

    // Read the two sources {0,idx} and {1,idx} from the published bank
    assign rd_lo = pub_q[{1'b0, idx}];
    assign rd_hi = pub_q[{1'b1, idx}];

    // Detect a staging metric that reached the top bit
    always_comb begin
        any_top = 1'b0;
        for (int i = 0; i < NS; i++) begin
            any_top = any_top | stg_q[i][MW-1];
        end
    end

    // Staging writes for destinations {idx,0} and {idx,1}
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                stg_q[i] <= '0;
            end
            dec_stg_q <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < 2; b++) begin
                stg_q[{idx, 1'(b)}]     <= wr_pm[b];
                dec_stg_q[{idx, 1'(b)}] <= wr_dec[b];
            end
        end
    end

    // Publish staging bank, rescaled when needed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                pub_q[i] <= (i == 0) ? MW'(INIT_BIAS) : '0;
            end
            dec_pub_q <= '0;
        end else if (commit) begin
            for (int i = 0; i < NS; i++) begin
                pub_q[i] <= any_top ? (stg_q[i] >> 1) : stg_q[i];
            end
            dec_pub_q <= dec_stg_q;
        end
    end

    // Flatten published state for the ports
    for (genvar k = 0; k < NS; k++) begin : g_flat
        assign pm_flat[k*MW +: MW] = pub_q[k];
    end
    assign dec_flat = dec_pub_q;

endmodule

// File: rtl/vit_pm_engine.sv
// Top: one trellis step of a rate-1/2, 2^SW-state hard-decision Viterbi
// decoder per accepted symbol. One butterfly per clock; done pulses once
// the new metrics and decisions are published. Assumes INIT_BIAS < 2^(MW-1).
module vit_pm_engine #(
    parameter int            SW        = 5,
    parameter int            MW        = 8,
    parameter logic [SW:0]   G0        = 6'b101101,
    parameter logic [SW:0]   G1        = 6'b110111,
    parameter int            INIT_BIAS = 64,
    localparam int NS = 1 << SW,
    localparam int NB = NS / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [1:0]       sym_data,
    output logic             sym_ready,
    output logic             done,
    output logic [NS*MW-1:0] pm_out,
    output logic [NS-1:0]    dec_out
);
    localparam int IW = SW - 1;

    logic          accept;
    logic          bfly_en;
    logic [IW-1:0] bfly_idx;
    logic          commit;
    logic [1:0]    sym_q;
    logic [MW-1:0] rd_lo;
    logic [MW-1:0] rd_hi;
    logic [MW-1:0] acs_pm [2];
    logic          acs_dec [2];

    // Hold the accepted symbol for the whole step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q <= '0;
        end else if (accept) begin
            sym_q <= sym_data;
        end
    end

    vit_ctrl #(.NB(NB)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_ready (sym_ready),
        .accept    (accept),
        .bfly_en   (bfly_en),
        .bfly_idx  (bfly_idx),
        .commit    (commit),
        .done      (done)
    );

    vit_acs #(.SW(SW), .MW(MW), .G0(G0), .G1(G1)) u_acs (
        .pair_id (bfly_idx),
        .pm_lo   (rd_lo),
        .pm_hi   (rd_hi),
        .sym     (sym_q),
        .new_pm  (acs_pm),
        .new_dec (acs_dec)
    );

    vit_metric_bank #(.SW(SW), .MW(MW), .INIT_BIAS(INIT_BIAS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (bfly_idx),
        .rd_lo    (rd_lo),
        .rd_hi    (rd_hi),
        .wr_en    (bfly_en),
        .wr_pm    (acs_pm),
        .wr_dec   (acs_dec),
        .commit   (commit),
        .pm_flat  (pm_out),
        .dec_flat (dec_out)
    );

endmodule

// File: rtl/vit_pm_engine_chk.sv
// Checker for vit_pm_engine: handshake, pulse timing, metric range and
// output hold properties, bound to every instance of the top.
module vit_pm_engine_chk #(
    parameter int SW = 5,
    parameter int MW = 8,
    localparam int NS  = 1 << SW,
    localparam int LAT = (NS / 2) + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_valid,
    input logic             sym_ready,
    input logic             done,
    input logic [NS*MW-1:0] pm_out,
    input logic [NS-1:0]    dec_out
);
    logic [7:0] lat_cnt;
    logic       top_set;

    // Cycles since the accepting edge (1 right after it, 0 when idle)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (sym_valid && sym_ready) begin
            lat_cnt <= 8'd1;
        end else if (done) begin
            lat_cnt <= '0;
        end else if (lat_cnt != 0) begin
            lat_cnt <= lat_cnt + 8'd1;
        end
    end

    // Any published metric with its top bit set
    always_comb begin
        top_set = 1'b0;
        for (int k = 0; k < NS; k++) begin
            top_set = top_set | pm_out[k*MW + MW - 1];
        end
    end

    // R1
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_ready) |=> !sym_ready);

    // R1
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_cnt != 0 && !done) |-> !sym_ready);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == 8'(LAT)));

    // R7
    metric_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !top_set);

    // R9
    metric_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pm_out) |-> done);

    // R9
    decision_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dec_out) |-> done);

endmodule

bind vit_pm_engine vit_pm_engine_chk #(.SW(SW), .MW(MW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .done      (done),
    .pm_out    (pm_out),
    .dec_out   (dec_out)
);

// File: tb/tb_vit_pm_engine.sv
// Scoreboard bench: the driver steps an independent trellis model and
// queues expected results; the monitor compares them on each done pulse.
module tb_vit_pm_engine;
    localparam int NS  = 32;
    localparam int MW  = 8;
    localparam int PMW = NS * MW;
    localparam logic [5:0] POLY_A = 6'b101101;
    localparam logic [5:0] POLY_B = 6'b110111;

    typedef struct {
        logic [PMW-1:0] pm;
        logic [NS-1:0]  dec;
        int             acc_cyc;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sym_valid = 1'b0;
    logic [1:0]     sym_data = 2'b00;
    logic           sym_ready;
    logic           done;
    logic [PMW-1:0] pm_out;
    logic [NS-1:0]  dec_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int sent = 0;
    int seen = 0;
    int halvings = 0;
    int mdl_pm [NS];
    exp_t sb_q [$];

    vit_pm_engine dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_data  (sym_data),
        .sym_ready (sym_ready),
        .done      (done),
        .pm_out    (pm_out),
        .dec_out   (dec_out)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [PMW-1:0] act,
                         input logic [PMW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected encoder bit: parity of {u,s} masked by poly
    function automatic int enc_bit(input int u, input int s, input logic [5:0] poly);
        logic [5:0] w;
        int ones;
        w = {1'(u), 5'(s)} & poly;
        ones = 0;
        for (int i = 0; i < 6; i++) ones += w[i];
        return ones % 2;
    endfunction

    function automatic int agree(input int u, input int s, input logic [1:0] sym);
        int a;
        a = 0;
        if (enc_bit(u, s, POLY_A) == int'(sym[1])) a++;
        if (enc_bit(u, s, POLY_B) == int'(sym[0])) a++;
        return a;
    endfunction

    // One trellis step of the model (R4, R5, R6, R7, R8)
    task automatic model_step(input logic [1:0] sym, output exp_t e);
        int nxt [NS];
        int top;
        top = 0;
        for (int d = 0; d < NS; d++) begin
            int u, s0, s1, c0, c1;
            u  = d % 2;
            s0 = d / 2;
            s1 = d / 2 + NS / 2;
            c0 = mdl_pm[s0] + agree(u, s0, sym);
            c1 = mdl_pm[s1] + agree(u, s1, sym);
            nxt[d]   = (c1 > c0) ? c1 : c0;
            e.dec[d] = (c1 > c0);
            if (nxt[d] >= 128) top = 1;
        end
        if (top != 0) halvings++;
        for (int d = 0; d < NS; d++) begin
            mdl_pm[d] = (top != 0) ? nxt[d] / 2 : nxt[d];
            e.pm[d*MW +: MW] = MW'(mdl_pm[d]);
        end
    endtask

    // Driver: offer a symbol, optionally keep valid high with noise (R10)
    task automatic send(input logic [1:0] sym, input bit noisy);
        exp_t e;
        @(negedge clk);
        while (!sym_ready) @(negedge clk);
        sym_valid = 1'b1;
        sym_data  = sym;
        model_step(sym, e);
        e.acc_cyc = cyc + 1;
        sb_q.push_back(e);
        sent++;
        @(negedge clk);
        if (noisy) begin
            for (int i = 0; i < 12; i++) begin
                sym_data = ~sym ^ 2'(i);
                // R1: busy engine must not offer ready
                check(sym_ready == 1'b0, "R1 ready during step", PMW'(sym_ready), '0);
                @(negedge clk);
            end
        end
        sym_valid = 1'b0;
    endtask

    // Monitor: compare each published step with the queued expectation
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            seen++;
            if (sb_q.size() == 0) begin
                check(1'b0, "R2 unexpected done", PMW'(seen), PMW'(sent));
            end else begin
                e = sb_q.pop_front();
                // R5 R8 R10 metrics, R6 decisions, R2 latency
                check(pm_out == e.pm, "R5 metrics", pm_out, e.pm);
                check(dec_out == e.dec, "R6 decisions", PMW'(dec_out), PMW'(e.dec));
                check(cyc == e.acc_cyc + 17, "R2 latency", PMW'(cyc - e.acc_cyc), PMW'(17));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", PMW'(cyc), '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < NS; k++) mdl_pm[k] = (k == 0) ? 64 : 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        check(pm_out[7:0] == 8'd64, "R3 state0 bias", PMW'(pm_out[7:0]), PMW'(64));
        check(pm_out[PMW-1:8] == '0, "R3 other metrics", PMW'(pm_out[PMW-1:8]), '0);
        check(dec_out == '0, "R3 decisions", PMW'(dec_out), '0);
        check(sym_ready == 1'b1 && done == 1'b0, "R3 handshake", PMW'({sym_ready, done}), PMW'(2'b10));
        // R4: worked example, source 00100 input 1 gives 00, scores 0 against 11
        check(enc_bit(1, 4, POLY_A) == 0 && enc_bit(1, 4, POLY_B) == 0 && agree(1, 4, 2'b11) == 0,
              "R4 branch example", PMW'(agree(1, 4, 2'b11)), '0);

        // R4 R5 R6: each symbol value once
        send(2'b11, 1'b0);
        send(2'b00, 1'b0);
        send(2'b01, 1'b0);
        send(2'b10, 1'b0);
        // R10: busy-time valid and data changes are ignored
        send(2'b01, 1'b1);
        // R7: long run to force rescaling
        for (int n = 0; n < 60; n++) send(2'($urandom_range(0, 3)), 1'b0);
        for (int n = 0; n < 60; n++) send(2'b11, 1'b0);

        repeat (30) @(negedge clk);
        check(sb_q.size() == 0 && seen == sent, "R2 one done per symbol", PMW'(seen), PMW'(sent));
        check(halvings > 0, "R7 rescaling exercised", PMW'(halvings), PMW'(1));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule